// File: doc/BRIEF.md
# Runahead Mode Entry and Exit Controller

This controller lets a simple pipelined core keep executing past a load that has missed in the last-level cache and is blocking retirement. It does not stall. When the stall is reported in normal operation, the controller takes a snapshot of three pieces of state: the architectural register file, the branch global-history register and the return-address-stack top pointer. It also captures the PC and the memory ID of the blocking load, and it tells the pipeline to retire that load at once with its destination marked invalid. The core then runs ahead speculatively, and every result it produces in this mode is later thrown away.

When memory returns the data for the captured ID, the controller leaves runahead mode through a two-cycle exit sequence. In the first cycle it flushes everything in flight. In the second cycle it keeps the flush asserted and also drives three things together: the restore strobe, the snapshot contents and a fetch redirect to the PC of the blocking load. That load is then fetched again and finds its data. The pipeline, the caches and the predictors are outside this block.

Top module: `runahead_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the mode flag is low and the checkpoint, invalid-retire, flush, restore and redirect strobes are all low.
- R2: A miss-stall seen in normal operation raises the checkpoint and invalid-retire strobes in that same cycle, with no clock delay. The mode flag is high from the next cycle on.
- R3: The restore outputs for the register file, history and stack pointer equal the values that were on the state inputs in the cycle the checkpoint strobe was high.
- R4: A miss-stall seen while the mode flag is high takes no new checkpoint and does not change the captured trigger PC or ID.
- R5: Ignored memory returns: one whose ID differs from the trigger ID, one that arrives in normal operation, and one that arrives during the exit sequence. None of these changes the mode or raises flush.
- R6: A memory return that matches the trigger ID while in runahead mode gives exactly one following cycle in which flush is high and restore and redirect are low.
- R7: In the cycle after that, flush, restore and redirect are all high together, and the redirect PC equals the trigger PC.
- R8: In the cycle after the restore, the mode flag is low and a new miss-stall is accepted again.
- R9: Restore and redirect are never high without flush. Flush is never high while the mode flag is low. The checkpoint strobe is never high while the mode flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_stall_i | input | 1 | A load missed in the last-level cache and blocks retirement |
| miss_pc_i | input | PC_W | PC of the stalling load |
| miss_tag_i | input | TAG_W | Memory request ID of the stalling load |
| fill_valid_i | input | 1 | Memory returned data this cycle |
| fill_tag_i | input | TAG_W | ID of the returned request |
| arf_i | input | NREG*XLEN | Current architectural registers, register k at bits k*XLEN upward |
| ghr_i | input | GHR_W | Current branch global-history register |
| ras_top_i | input | RASP_W | Current return-address-stack top pointer |
| ra_mode_o | output | 1 | High in runahead mode and during the exit sequence |
| ckpt_o | output | 1 | Checkpoint taken this cycle |
| inv_retire_o | output | 1 | Retire the blocking load now with an invalid destination |
| flush_o | output | 1 | Flush every in-flight instruction |
| restore_o | output | 1 | Load the restore outputs back into the architectural state |
| redirect_o | output | 1 | Redirect fetch |
| redirect_pc_o | output | PC_W | Fetch target; holds the trigger PC |
| rest_arf_o | output | NREG*XLEN | Checkpointed register file |
| rest_ghr_o | output | GHR_W | Checkpointed global history |
| rest_ras_o | output | RASP_W | Checkpointed stack pointer |

## Verification
The assertions assume the control inputs carry known values once reset is released. They also assume that the ID inputs matter only while their valid strobes are high. The stimulus holds every input at zero during reset and drives each input at the falling edge. Across the random phase, memory-return IDs are drawn from a small set, so matching returns, stale returns and returns during the exit sequence all happen often. The sequence never depends on a matching return arriving, because the bench model follows whatever order the events come in.

// File: rtl/runahead_ctl.sv
module runahead_ctl #(
  parameter int NREG   = 8,
  parameter int XLEN   = 32,
  parameter int PC_W   = 32,
  parameter int TAG_W  = 6,
  parameter int GHR_W  = 16,
  parameter int RASP_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 miss_stall_i,
  input  logic [PC_W-1:0]      miss_pc_i,
  input  logic [TAG_W-1:0]     miss_tag_i,
  input  logic                 fill_valid_i,
  input  logic [TAG_W-1:0]     fill_tag_i,
  input  logic [NREG*XLEN-1:0] arf_i,
  input  logic [GHR_W-1:0]     ghr_i,
  input  logic [RASP_W-1:0]    ras_top_i,
  output logic                 ra_mode_o,
  output logic                 ckpt_o,
  output logic                 inv_retire_o,
  output logic                 flush_o,
  output logic                 restore_o,
  output logic                 redirect_o,
  output logic [PC_W-1:0]      redirect_pc_o,
  output logic [NREG*XLEN-1:0] rest_arf_o,
  output logic [GHR_W-1:0]     rest_ghr_o,
  output logic [RASP_W-1:0]    rest_ras_o
);
  localparam int ARF_W = NREG * XLEN;

  typedef enum logic [1:0] {NORMAL, RUNAHEAD, EXIT_FLUSH} mode_t;

  mode_t              state;
  logic               exit_ph;
  logic [PC_W-1:0]    trig_pc;
  logic [TAG_W-1:0]   trig_tag;
  logic [ARF_W-1:0]   ck_arf;
  logic [GHR_W-1:0]   ck_ghr;
  logic [RASP_W-1:0]  ck_ras;

  wire enter = (state == NORMAL) && miss_stall_i;
  wire wake  = (state == RUNAHEAD) && fill_valid_i && (fill_tag_i == trig_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= NORMAL;
      exit_ph  <= 1'b0;
      trig_pc  <= '0;
      trig_tag <= '0;
      ck_arf   <= '0;
      ck_ghr   <= '0;
      ck_ras   <= '0;
    end else begin
      case (state)
        NORMAL: if (enter) begin
          state    <= RUNAHEAD;
          trig_pc  <= miss_pc_i;
          trig_tag <= miss_tag_i;
          ck_arf   <= arf_i;
          ck_ghr   <= ghr_i;
          ck_ras   <= ras_top_i;
        end
        RUNAHEAD: if (wake) begin
          state   <= EXIT_FLUSH;
          exit_ph <= 1'b0;
        end
        EXIT_FLUSH: begin
          exit_ph <= ~exit_ph;
          if (exit_ph) state <= NORMAL;
        end
        default: state <= NORMAL;
      endcase
    end
  end

  assign ra_mode_o     = (state != NORMAL);
  assign ckpt_o        = enter;
  assign inv_retire_o  = enter;
  assign flush_o       = (state == EXIT_FLUSH);
  assign restore_o     = (state == EXIT_FLUSH) && exit_ph;
  assign redirect_o    = restore_o;
  assign redirect_pc_o = trig_pc;
  assign rest_arf_o    = ck_arf;
  assign rest_ghr_o    = ck_ghr;
  assign rest_ras_o    = ck_ras;
endmodule

module runahead_ctl_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ra_mode_o,
  input logic            ckpt_o,
  input logic            flush_o,
  input logic            restore_o,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o
);
  // R2
  ckpt_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_o |=> ra_mode_o);
  // R9
  ckpt_only_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_o |-> !ra_mode_o);
  // R9
  restore_with_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_o || redirect_o) |-> (flush_o && restore_o && redirect_o));
  // R9
  flush_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> ra_mode_o);
  // R7
  second_flush_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o && !restore_o) |=> (flush_o && restore_o));
  // R8
  restore_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |=> !ra_mode_o);
  // R4
  pc_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode_o && $past(ra_mode_o)) |-> $stable(redirect_pc_o));
endmodule

bind runahead_ctl runahead_ctl_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ra_mode_o(ra_mode_o), .ckpt_o(ckpt_o),
  .flush_o(flush_o), .restore_o(restore_o), .redirect_o(redirect_o),
  .redirect_pc_o(redirect_pc_o));

// File: tb/test_runahead_ctl.sv
module test_runahead_ctl;
  localparam int NREG = 8, XLEN = 32, PC_W = 32, TAG_W = 6, GHR_W = 16, RASP_W = 4;
  localparam int ARF_W = NREG * XLEN;

  logic clk = 0, rst_n = 0;
  logic miss = 0, fill = 0;
  logic [PC_W-1:0] mpc = '0;
  logic [TAG_W-1:0] mtag = '0, ftag = '0;
  logic [ARF_W-1:0] arf = '0;
  logic [GHR_W-1:0] ghr = '0;
  logic [RASP_W-1:0] ras = '0;
  logic mode, ckpt, invr, flush, rest, redir;
  logic [PC_W-1:0] rpc;
  logic [ARF_W-1:0] rarf;
  logic [GHR_W-1:0] rghr;
  logic [RASP_W-1:0] rras;

  runahead_ctl i_runahead_ctl (
    .clk(clk), .rst_n(rst_n), .miss_stall_i(miss), .miss_pc_i(mpc), .miss_tag_i(mtag),
    .fill_valid_i(fill), .fill_tag_i(ftag), .arf_i(arf), .ghr_i(ghr), .ras_top_i(ras),
    .ra_mode_o(mode), .ckpt_o(ckpt), .inv_retire_o(invr), .flush_o(flush),
    .restore_o(rest), .redirect_o(redir), .redirect_pc_o(rpc),
    .rest_arf_o(rarf), .rest_ghr_o(rghr), .rest_ras_o(rras));

  always #4 clk = ~clk;

  int vectors = 0, bad = 0;
  int ms = 0;  // 0 normal, 1 runahead, 2 exit first, 3 exit second
  logic [PC_W-1:0] m_pc = '0;
  logic [TAG_W-1:0] m_tag = '0;
  logic [ARF_W-1:0] m_arf = '0;
  logic [GHR_W-1:0] m_ghr = '0;
  logic [RASP_W-1:0] m_ras = '0;

  task automatic chk(input string req, input string what, input logic [ARF_W-1:0] act, input logic [ARF_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    logic e_ck;
    e_ck = (ms == 0) && miss;
    chk(req, "mode", ARF_W'(mode), ARF_W'(ms != 0));
    chk(req, "ckpt", ARF_W'(ckpt), ARF_W'(e_ck));
    chk(req, "inv_retire", ARF_W'(invr), ARF_W'(e_ck));
    chk(req, "flush", ARF_W'(flush), ARF_W'(ms >= 2));
    chk(req, "restore", ARF_W'(rest), ARF_W'(ms == 3));
    chk(req, "redirect", ARF_W'(redir), ARF_W'(ms == 3));
    if (ms != 0) chk(req, "redirect_pc", ARF_W'(rpc), ARF_W'(m_pc));
    if (ms == 3) begin
      chk(req, "rest_arf", rarf, m_arf);
      chk(req, "rest_ghr", ARF_W'(rghr), ARF_W'(m_ghr));
      chk(req, "rest_ras", ARF_W'(rras), ARF_W'(m_ras));
    end
  endtask

  task automatic step(input logic i_miss, input logic [PC_W-1:0] i_pc, input logic [TAG_W-1:0] i_tag,
                      input logic i_fill, input logic [TAG_W-1:0] i_ftag, input string req);
    @(negedge clk);
    miss = i_miss; mpc = i_pc; mtag = i_tag; fill = i_fill; ftag = i_ftag;
    for (int k = 0; k < NREG; k++) arf[k*XLEN +: XLEN] = $urandom;
    ghr = GHR_W'($urandom); ras = RASP_W'($urandom);
    #1 compare(req);
    @(posedge clk);
    case (ms)
      0: if (miss) begin ms = 1; m_pc = mpc; m_tag = mtag; m_arf = arf; m_ghr = ghr; m_ras = ras; end
      1: if (fill && ftag == m_tag) ms = 2;
      2: ms = 3;
      default: ms = 0;
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs quiet in reset
    compare("R1");
    rest_n_release();
    step(0, 0, 0, 0, 0, "R1");
    // R2 R3 entry
    step(1, 32'h1000, 6'd5, 0, 0, "R2");
    step(0, 0, 0, 0, 0, "R2");
    // R4 nested miss ignored
    step(1, 32'h2000, 6'd9, 0, 0, "R4");
    // R5 wrong tag
    step(0, 0, 0, 1, 6'd9, "R5");
    step(0, 0, 0, 0, 0, "R5");
    // R6 matching return
    step(0, 0, 0, 1, 6'd5, "R6");
    step(1, 32'h3000, 6'd1, 1, 6'd5, "R6");
    // R7 restore + redirect, R3 contents
    step(0, 0, 0, 0, 0, "R7");
    // R8 back to normal, immediate re-entry
    step(1, 32'h4000, 6'd2, 0, 0, "R8");
    step(0, 0, 0, 1, 6'd2, "R6");
    step(0, 0, 0, 1, 6'd2, "R5");
    step(0, 0, 0, 0, 0, "R3");
    // R5 return in normal mode
    step(0, 0, 0, 1, 6'd2, "R5");
    step(0, 0, 0, 0, 0, "R5");
    for (int n = 0; n < 3000; n++)
      step(($urandom % 4) == 0, $urandom, TAG_W'($urandom % 4), ($urandom % 3) == 0,
           TAG_W'($urandom % 4), "R9");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  task automatic rest_n_release();
    @(posedge clk);
    #1 rst_n = 1;
  endtask
endmodule